// File: doc/BRIEF.md
# Word atomic read-modify-write sequencer

This block carries out a 32-bit atomic memory instruction as a read-modify-write sequence on a simple single-beat memory port. The core presents a decoded instruction word, the pc of that instruction and the two source register values. After accepting the instruction, the block reads the addressed word and combines it with the operand using one of eight operations. It then writes the new value back and hands the old memory value to the destination register.

The decode stage is part of the block. An instruction with the wrong major opcode, a width other than word, or an operation the block does not support is rejected with an illegal pulse, and no memory traffic follows. A fault reported on either memory phase stops the sequence at once. In that case the block raises a precise trap carrying the faulting instruction's pc and does not produce a destination write. A sequence that completes normally ends with a one-cycle completion pulse that carries the destination index, the old value and the next pc.

Top module: `amo_rmw_unit`

## Requirements
- R1: An instruction is accepted only when instr[6:0] is 0x2F and instr[14:12] is 2. Any other instruction with start high in idle gives `illegal` high for exactly the next cycle, issues no memory request and leaves `busy` low.
- R2: The operation is instr[31:27]. Supported codes: 0x00 add, 0x04 xor, 0x08 or, 0x0C and, 0x10 signed min, 0x14 signed max, 0x18 unsigned min, 0x1C unsigned max. Any other code is treated as illegal, as in R1. Bits [26:25] are ignored.
- R3: Both memory requests use `rs1_val` as the address. The operand is `rs2_val`. `rd_idx` is instr[11:7].
- R4: For add, xor, or and and, the write data is the old memory word combined with the operand; add wraps modulo 2^32.
- R5: For min and max, bit 3 of the select picks an unsigned (1) or two's-complement (0) compare, and bit 2 picks max (1) or min (0).
- R6: On success, `done` is high for one cycle, with `rd_val` equal to the word read (not the result) and `pc_out` equal to pc+4.
- R7: The read request comes first. The write request is issued only after an error-free read response. Each request is high for a single cycle.
- R8: A read response with `mem_err` raises `trap` for one cycle with `trap_on_write` low and `pc_out` equal to the instruction pc. No write and no `done` follow.
- R9: A write response with `mem_err` raises `trap` for one cycle with `trap_on_write` high and `pc_out` equal to the instruction pc. No `done` follows.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle, and it is already low in the `trap` cycle. A `start` while busy is ignored.
- R11: The read request is high in the first cycle after acceptance. The block waits any number of cycles for each `mem_ack`.
- R12: After reset, `busy`, `mem_req`, `done`, `trap` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction present |
| instr | input | 32 | Instruction word |
| pc | input | PC_W | Instruction pc |
| rs1_val | input | 32 | Address register value |
| rs2_val | input | 32 | Operand register value |
| busy | output | 1 | Sequence in progress |
| illegal | output | 1 | Rejected instruction pulse |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Response valid |
| mem_err | input | 1 | Response is a fault |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Completion pulse |
| rd_idx | output | 5 | Destination index |
| rd_val | output | 32 | Old memory value |
| trap | output | 1 | Fault pulse |
| trap_on_write | output | 1 | Fault came from the write phase |
| pc_out | output | PC_W | Next pc on done, instruction pc on trap |

## Verification
With read latency Lr and write latency Lw counted in cycles from the request to the acknowledgment, the results fall due at fixed cycles after the start edge:
- The read request is due in cycle 1.
- The write request is due in cycle 2+Lr.
- `done` or a write `trap` is due in cycle 3+Lr+Lw.
- A read `trap` is due in cycle 2+Lr.
- An `illegal` is due in cycle 1.

The bench drives the acknowledgments itself, so these cycle numbers are known in advance. It predicts every output for each cycle from that timeline and samples on the falling edge, half a period clear of the register updates. Operations are run with latencies from 1 to 7 cycles, and starts arrive mid-sequence, to confirm that waiting and ignored input leave the predicted cycles unchanged.

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [PC_W-1:0] pc,
  input  logic [31:0]     rs1_val,
  input  logic [31:0]     rs2_val,
  output logic            busy,
  output logic            illegal,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [31:0]     mem_rdata,
  output logic            done,
  output logic [4:0]      rd_idx,
  output logic [31:0]     rd_val,
  output logic            trap,
  output logic            trap_on_write,
  output logic [PC_W-1:0] pc_out
);

  localparam int         XLEN    = 32;
  localparam logic [6:0] OPC_AMO = 7'h2F;
  localparam logic [2:0] WIDTH_W = 3'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RREQ, S_RWAIT, S_WREQ, S_WWAIT, S_DONE
  } st_t;

  st_t            st;
  logic [4:0]     sel_q;
  logic [XLEN-1:0] addr_q, opnd_q, old_q, alu_res;
  logic [4:0]     rd_q;
  logic [PC_W-1:0] pc_q;
  logic           illegal_q, trap_q, trap_wr_q;
  logic           sel_ok, dec_ok;
  logic           lt_opnd, lt_old;

  logic unused_fields;
  assign unused_fields = ^instr[26:15];

  always_comb begin
    case (instr[31:27])
      5'h00, 5'h04, 5'h08, 5'h0C,
      5'h10, 5'h14, 5'h18, 5'h1C: sel_ok = 1'b1;
      default:                    sel_ok = 1'b0;
    endcase
  end

  assign dec_ok = (instr[6:0] == OPC_AMO) && (instr[14:12] == WIDTH_W) && sel_ok;

  assign lt_opnd = sel_q[3] ? (opnd_q < old_q) : ($signed(opnd_q) < $signed(old_q));
  assign lt_old  = sel_q[3] ? (old_q < opnd_q) : ($signed(old_q) < $signed(opnd_q));

  always_comb begin
    case (sel_q[4:2])
      3'b000:  alu_res = opnd_q + old_q;
      3'b001:  alu_res = opnd_q ^ old_q;
      3'b010:  alu_res = opnd_q | old_q;
      3'b011:  alu_res = opnd_q & old_q;
      default: alu_res = sel_q[2] ? (lt_old ? opnd_q : old_q)
                                  : (lt_opnd ? opnd_q : old_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sel_q     <= '0;
      addr_q    <= '0;
      opnd_q    <= '0;
      old_q     <= '0;
      rd_q      <= '0;
      pc_q      <= '0;
      illegal_q <= 1'b0;
      trap_q    <= 1'b0;
      trap_wr_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      trap_q    <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (dec_ok) begin
            st     <= S_RREQ;
            sel_q  <= instr[31:27];
            rd_q   <= instr[11:7];
            addr_q <= rs1_val;
            opnd_q <= rs2_val;
            pc_q   <= pc;
          end else begin
            illegal_q <= 1'b1;
          end
        end
        S_RREQ: st <= S_RWAIT;
        S_RWAIT: if (mem_ack) begin
          if (mem_err) begin
            trap_q    <= 1'b1;
            trap_wr_q <= 1'b0;
            st        <= S_IDLE;
          end else begin
            old_q <= mem_rdata;
            st    <= S_WREQ;
          end
        end
        S_WREQ: st <= S_WWAIT;
        S_WWAIT: if (mem_ack) begin
          if (mem_err) begin
            trap_q    <= 1'b1;
            trap_wr_q <= 1'b1;
            st        <= S_IDLE;
          end else begin
            st <= S_DONE;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign illegal       = illegal_q;
  assign mem_req       = (st == S_RREQ) || (st == S_WREQ);
  assign mem_we        = (st == S_WREQ);
  assign mem_addr      = addr_q;
  assign mem_wdata     = alu_res;
  assign done          = (st == S_DONE);
  assign rd_idx        = rd_q;
  assign rd_val        = old_q;
  assign trap          = trap_q;
  assign trap_on_write = trap_q && trap_wr_q;
  assign pc_out        = (st == S_DONE) ? pc_q + PC_W'(4) : pc_q;

endmodule

// File: rtl/amo_rmw_unit_chk.sv
module amo_rmw_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic illegal,
  input logic mem_req,
  input logic mem_we,
  input logic mem_ack,
  input logic mem_err,
  input logic done,
  input logic trap
);

  logic last_we, read_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_we <= 1'b0;
      read_ok <= 1'b0;
    end else begin
      if (mem_req) last_we <= mem_we;
      if (mem_req && mem_we) read_ok <= 1'b0;
      else if (mem_ack && !mem_err && !last_we) read_ok <= 1'b1;
      else if (mem_ack && mem_err) read_ok <= 1'b0;
    end
  end

  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !mem_req));

  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> read_ok);

  a_r7_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && trap));

  a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(done) || trap));

endmodule

bind amo_rmw_unit amo_rmw_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .illegal(illegal),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_err(mem_err),
  .done(done), .trap(trap)
);

// File: tb/amo_rmw_unit_test.sv
module amo_rmw_unit_test;

  localparam logic [31:0] BASE = 32'h8000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0, rs1_val = '0, rs2_val = '0, pc = '0;
  logic        busy, illegal, mem_req, mem_we, done, trap, trap_on_write;
  logic [31:0] mem_addr, mem_wdata, rd_val, pc_out;
  logic [4:0]  rd_idx;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = 32'hDEAD_BEEF;

  logic [31:0] mem_m [16];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  amo_rmw_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .busy(busy), .illegal(illegal),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .done(done), .rd_idx(rd_idx), .rd_val(rd_val),
    .trap(trap), .trap_on_write(trap_on_write), .pc_out(pc_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_op(input logic [4:0] sel,
                                         input logic [31:0] m, input logic [31:0] s);
    longint sm, ss;
    sm = longint'($signed(m));
    ss = longint'($signed(s));
    case (sel)
      5'h00: return m + s;
      5'h04: return m ^ s;
      5'h08: return m | s;
      5'h0C: return m & s;
      5'h10: return (ss < sm) ? s : m;
      5'h14: return (ss > sm) ? s : m;
      5'h18: return (s < m) ? s : m;
      default: return (s > m) ? s : m;
    endcase
  endfunction

  task automatic run_op(input logic [4:0] sel, input int idx, input logic [31:0] opnd,
                        input logic [4:0] rd, input logic [31:0] pcv,
                        input int lr, input int lw, input bit frd, input bit fwr,
                        input bit poke);
    logic [31:0] a, old, res;
    int last;
    string rq;
    a    = BASE + 32'(idx * 4);
    old  = mem_m[idx];
    res  = ref_op(sel, old, opnd);
    last = frd ? 2 + lr : 3 + lr + lw;
    rq   = sel[4] ? "R5" : "R4";
    @(negedge clk);
    start   = 1'b1;
    instr   = {sel, 2'b11, 5'd2, 5'd1, 3'b010, rd, 7'h2F};
    rs1_val = a;
    rs2_val = opnd;
    pc      = pcv;
    for (int c = 1; c <= last + 1; c++) begin
      bit e_busy, e_req, e_we, e_done, e_trap;
      @(negedge clk);
      start = 1'b0;
      e_busy = (c < last) || (c == last && !frd && !fwr);
      e_req  = (c == 1) || (!frd && c == 2 + lr);
      e_we   = !frd && c == 2 + lr;
      e_done = (c == last) && !frd && !fwr;
      e_trap = (c == last) && (frd || fwr);
      chk(busy == e_busy, "R10", "busy", 32'(busy), 32'(e_busy));
      chk(mem_req == e_req, "R11", "mem_req", 32'(mem_req), 32'(e_req));
      chk(done == e_done, "R6", "done", 32'(done), 32'(e_done));
      chk(trap == e_trap, frd ? "R8" : "R9", "trap", 32'(trap), 32'(e_trap));
      if (e_req) begin
        chk(mem_we == e_we, "R7", "mem_we", 32'(mem_we), 32'(e_we));
        chk(mem_addr == a, "R3", "mem_addr", mem_addr, a);
      end
      if (e_we) chk(mem_wdata == res, rq, "mem_wdata", mem_wdata, res);
      if (e_done) begin
        chk(rd_val == old, "R6", "rd_val", rd_val, old);
        chk(rd_idx == rd, "R3", "rd_idx", 32'(rd_idx), 32'(rd));
        chk(pc_out == pcv + 4, "R6", "pc_out", pc_out, pcv + 4);
      end
      if (e_trap) begin
        chk(pc_out == pcv, frd ? "R8" : "R9", "pc_out", pc_out, pcv);
        chk(trap_on_write == fwr, frd ? "R8" : "R9", "trap_on_write",
            32'(trap_on_write), 32'(fwr));
      end
      mem_ack   = (c == 1 + lr) || (!frd && c == 2 + lr + lw);
      mem_err   = (c == 1 + lr && frd) || (!frd && c == 2 + lr + lw && fwr);
      mem_rdata = (c == 1 + lr) ? old : 32'hDEAD_BEEF;
      if (poke && c == 2) begin
        start   = 1'b1;
        instr   = {5'h00, 2'b00, 5'd3, 5'd4, 3'b010, 5'd9, 7'h2F};
        rs1_val = 32'h1234_5678;
        rs2_val = 32'h1;
      end
    end
    mem_ack = 1'b0;
    mem_err = 1'b0;
    start   = 1'b0;
    if (!frd && !fwr) mem_m[idx] = res;
  endtask

  task automatic run_bad(input logic [31:0] iw, input string req);
    @(negedge clk);
    start   = 1'b1;
    instr   = iw;
    rs1_val = BASE;
    @(negedge clk);
    start = 1'b0;
    chk(illegal == 1'b1, req, "illegal", 32'(illegal), 32'd1);
    chk(busy == 1'b0, req, "busy", 32'(busy), 32'd0);
    chk(mem_req == 1'b0, req, "mem_req", 32'(mem_req), 32'd0);
    @(negedge clk);
    chk(illegal == 1'b0, req, "illegal_end", 32'(illegal), 32'd0);
    chk(mem_req == 1'b0 && busy == 1'b0, req, "quiet", 32'(mem_req), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = 32'h0101_0101 * 32'(i + 1);
    mem_m[3] = 32'hFFFF_FFF0;
    mem_m[4] = 32'h0000_0005;
    mem_m[5] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !trap && !illegal, "R12", "reset_outputs",
        {27'd0, busy, mem_req, done, trap, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !done && !trap && !illegal, "R12", "after_release",
        {27'd0, busy, mem_req, done, trap, illegal}, 32'd0);

    run_op(5'h00, 0, 32'hFFFF_FFFF, 5'd10, 32'h8000_0000, 1, 1, 0, 0, 0); // R4 add wrap
    run_op(5'h04, 1, 32'hA5A5_5A5A, 5'd11, 32'h8000_0010, 3, 2, 0, 0, 0); // R4 xor
    run_op(5'h08, 2, 32'h0F00_00F0, 5'd12, 32'h8000_0020, 2, 1, 0, 0, 0); // R4 or
    run_op(5'h0C, 2, 32'h00FF_FF00, 5'd13, 32'h8000_0030, 1, 4, 0, 0, 0); // R4 and
    run_op(5'h10, 3, 32'h0000_0007, 5'd14, 32'h8000_0040, 1, 1, 0, 0, 0); // R5 signed min
    run_op(5'h14, 4, 32'hFFFF_FFFE, 5'd15, 32'h8000_0050, 2, 2, 0, 0, 0); // R5 signed max
    run_op(5'h18, 3, 32'h0000_0007, 5'd16, 32'h8000_0060, 1, 1, 0, 0, 0); // R5 unsigned min
    run_op(5'h1C, 5, 32'h7FFF_FFFF, 5'd17, 32'h8000_0070, 1, 1, 0, 0, 0); // R5 unsigned max
    run_op(5'h10, 5, 32'h0000_0001, 5'd18, 32'h8000_0074, 1, 1, 0, 0, 0); // R5 signed min neg
    run_op(5'h00, 6, 32'h0000_0010, 5'd19, 32'h8000_0080, 4, 1, 1, 0, 0); // R8 read fault
    run_op(5'h04, 6, 32'h0000_0010, 5'd20, 32'h8000_0090, 2, 3, 0, 1, 0); // R9 write fault
    run_op(5'h00, 6, 32'h0000_0001, 5'd21, 32'h8000_00A0, 1, 1, 0, 0, 0); // R9 word unchanged
    run_op(5'h08, 7, 32'h0000_8000, 5'd22, 32'h8000_00B0, 7, 6, 0, 0, 1); // R10 R11 poke, long wait
    run_op(5'h00, 7, 32'h0000_0001, 5'd0,  32'h8000_00C0, 1, 1, 0, 0, 0); // R3 rd zero

    run_bad({5'h00, 2'b00, 5'd2, 5'd1, 3'b010, 5'd3, 7'h33}, "R1");      // wrong opcode
    run_bad({5'h00, 2'b00, 5'd2, 5'd1, 3'b011, 5'd3, 7'h2F}, "R1");      // doubleword width
    run_bad({5'h01, 2'b00, 5'd2, 5'd1, 3'b010, 5'd3, 7'h2F}, "R2");      // swap code
    run_bad({5'h02, 2'b00, 5'd0, 5'd1, 3'b010, 5'd3, 7'h2F}, "R2");      // load-reserved code
    run_bad({5'h1E, 2'b00, 5'd2, 5'd1, 3'b010, 5'd3, 7'h2F}, "R2");      // unused code

    run_op(5'h1C, 0, 32'h0000_0000, 5'd5, 32'h8000_00D0, 1, 2, 0, 0, 0); // R5 after illegal

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule